// File: doc/BRIEF.md
# Random Word Generator with Output Queue

This peripheral produces 32-bit pseudo-random words and hands them to software through a register bus of four word-sized registers. A 32-bit linear feedback shift register advances on every clock from reset onward, and software may stir extra material into it by writing the entropy register. Once the enable bit is set, a cadence counter lets the block drop one fresh word into a 16-entry output queue every 256 clock cycles. The queue is kept as full as it can be; a word falls due while the queue is full is simply not taken.

Software drains the queue by reading the output register, and each such read removes one word. Reading an empty queue yields zero and raises an error flag, which can drive an interrupt line unless it is masked. A write-one clear bit in the control register removes the error. A sleep bit halts the shift register and freezes the cadence, so no words arrive while it is set.

The bus is single-cycle: `bus_rdata` is valid combinationally while `bus_sel` is high with `bus_we` low, and any side effect (a queue pop, a register update) takes place at the next rising clock edge. `bus_word` selects the register by word index.

Top module: `rand_word_gen`

## Requirements
- R1: After reset the control register reads 0x0000_0000, the status register reads 0x0010_0000 and `irq` is low.
- R2: Control readback carries enable in bit 0, a high-assurance flag in bit 1, the interrupt mask in bit 2 and sleep in bit 4; bit 3 and bits 31:5 read zero. Word index 0 is control, 1 status, 2 entropy, 3 output. The entropy register reads zero, and writes to status or to the output register change nothing.
- R3: No word enters the queue while the enable bit is clear, however long the block runs.
- R4: With the enable bit set and sleep clear, a word enters the queue every 256 cycles; the first one lands on the 256th rising edge after the edge that stored the enable bit.
- R5: The queue fill level, status bits 15:8, never exceeds the capacity reported in status bits 23:16 (16); a word that falls due while the queue is full is dropped.
- R6: A read of the output register returns the oldest queued word and lowers the fill level by one at the following edge.
- R7: A read of the output register while the queue is empty returns zero and sets the error flag, status bit 2.
- R8: `irq` is high exactly when the error flag is set and the interrupt mask is clear.
- R9: Writing control with bit 3 set clears the error flag at the next edge.
- R10: While sleep is set, status bit 4 reads one, no word enters the queue and the cadence count is held; after sleep clears, counting resumes where it stopped.
- R11: A write to the entropy register is folded into the shift register without delaying the cadence, and consecutive queued words differ and are never zero.
- R12: Clearing the enable bit discards the partial cadence count, so a later enable again waits the full 256 cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_sel | input | 1 | Register access strobe |
| bus_we | input | 1 | 1 for write, 0 for read |
| bus_word | input | 2 | Register word index |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid while a read is selected |
| irq | output | 1 | Error interrupt request |

## Verification
The hardest state to reach from the ports is a sleep period that begins part-way through a cadence window, since the held count is invisible and shows only in when the next word lands. The bench enables generation, lets exactly 100 cycles pass, sleeps for 300 cycles, wakes the block and then samples the fill level on the 155th and 156th edges after waking. The cadence windows themselves are filled with seeded random entropy writes and ignored writes to read-only registers, so the exact landing edge of each word is checked while the shift register is being disturbed.

// File: rtl/rng_pkg.sv
package rng_pkg;
    localparam int DATA_W      = 32;
    localparam int FIFO_DEPTH  = 16;
    localparam int PUSH_PERIOD = 256;

    localparam logic [1:0] REG_CTRL = 2'd0;
    localparam logic [1:0] REG_STAT = 2'd1;
    localparam logic [1:0] REG_ENT  = 2'd2;
    localparam logic [1:0] REG_OUT  = 2'd3;

    localparam int CB_GO  = 0;
    localparam int CB_HA  = 1;
    localparam int CB_IM  = 2;
    localparam int CB_CI  = 3;
    localparam int CB_SLM = 4;

    localparam logic [31:0] LFSR_TAPS = 32'h0040_0007;
    localparam logic [31:0] LFSR_SEED = 32'hACE1_2468;

    typedef struct packed {
        logic go;
        logic ha;
        logic im;
        logic slm;
        logic ei;
    } ctl_t;
endpackage

// File: rtl/rng_lfsr.sv
module rng_lfsr #(
    parameter int          W    = 32,
    parameter logic [31:0] TAPS = 32'h0040_0007,
    parameter logic [31:0] SEED = 32'hACE1_2468
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         run,
    input  logic         mix_en,
    input  logic [W-1:0] mix_val,
    output logic [W-1:0] state
);
    localparam logic [W-1:0] TAP_V  = TAPS[W-1:0];
    localparam logic [W-1:0] SEED_V = SEED[W-1:0];

    logic [W-1:0] state_d, state_q, step;

    always_comb begin
        step = state_q;
        if (run) begin
            step = {state_q[W-2:0], 1'b0};
            if (state_q[W-1]) step = step ^ TAP_V;
        end
        state_d = step ^ (mix_en ? mix_val : '0);
        if (state_d == '0) state_d = SEED_V;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= SEED_V;
        else        state_q <= state_d;
    end

    assign state = state_q;

    // R11
    lfsr_moves_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (run && !mix_en) |=> (state_q != $past(state_q)));
endmodule

// File: rtl/rng_fifo.sv
module rng_fifo #(
    parameter int W     = 32,
    parameter int DEPTH = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               push,
    input  logic [W-1:0]       push_data,
    input  logic               pop,
    output logic [W-1:0]       head,
    output logic [$clog2(DEPTH):0] level,
    output logic               empty
);
    localparam int PTR_W = $clog2(DEPTH);
    localparam int CNT_W = PTR_W + 1;

    typedef struct packed {
        logic [DEPTH-1:0][W-1:0] mem;
        logic [PTR_W-1:0]        wp;
        logic [PTR_W-1:0]        rp;
        logic [CNT_W-1:0]        cnt;
    } fifo_st_t;

    fifo_st_t st_d, st_q;
    logic     do_push, do_pop;

    always_comb begin
        st_d    = st_q;
        do_push = push && (st_q.cnt != CNT_W'(DEPTH));
        do_pop  = pop && (st_q.cnt != '0);
        if (do_push) begin
            st_d.mem[st_q.wp] = push_data;
            st_d.wp = (st_q.wp == PTR_W'(DEPTH - 1)) ? '0 : st_q.wp + 1'b1;
        end
        if (do_pop) begin
            st_d.rp = (st_q.rp == PTR_W'(DEPTH - 1)) ? '0 : st_q.rp + 1'b1;
        end
        case ({do_push, do_pop})
            2'b10:   st_d.cnt = st_q.cnt + 1'b1;
            2'b01:   st_d.cnt = st_q.cnt - 1'b1;
            default: st_d.cnt = st_q.cnt;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign head  = st_q.mem[st_q.rp];
    assign level = st_q.cnt;
    assign empty = (st_q.cnt == '0);

    // R5
    lvl_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.cnt <= CNT_W'(DEPTH));

    // R6
    pop_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pop && !push && st_q.cnt == '0) |=> (st_q.cnt == '0));
endmodule

// File: rtl/rng_cadence.sv
module rng_cadence #(
    parameter int PERIOD = 256
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    input  logic clear,
    output logic tick
);
    localparam int CNT_W = (PERIOD > 1) ? $clog2(PERIOD) : 1;
    localparam logic [CNT_W-1:0] LAST = CNT_W'(PERIOD - 1);

    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        tick  = run && (cnt_q == LAST);
        cnt_d = cnt_q;
        if (clear)     cnt_d = '0;
        else if (tick) cnt_d = '0;
        else if (run)  cnt_d = cnt_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    // R4
    period_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> !tick);
endmodule

// File: rtl/rand_word_gen.sv
module rand_word_gen
    import rng_pkg::*;
#(
    parameter int DEPTH  = FIFO_DEPTH,
    parameter int PERIOD = PUSH_PERIOD
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        bus_sel,
    input  logic        bus_we,
    input  logic [1:0]  bus_word,
    input  logic [31:0] bus_wdata,
    output logic [31:0] bus_rdata,
    output logic        irq
);
    localparam int LVL_W = $clog2(DEPTH) + 1;

    ctl_t              ctl_d, ctl_q;
    logic              wr_ctl, wr_ent, rd_out;
    logic              tick, q_empty;
    logic [31:0]       rnd_word, q_head;
    logic [LVL_W-1:0]  q_level;

    always_comb begin
        wr_ctl = bus_sel && bus_we && (bus_word == REG_CTRL);
        wr_ent = bus_sel && bus_we && (bus_word == REG_ENT);
        rd_out = bus_sel && !bus_we && (bus_word == REG_OUT);

        ctl_d = ctl_q;
        if (wr_ctl) begin
            ctl_d.go  = bus_wdata[CB_GO];
            ctl_d.ha  = bus_wdata[CB_HA];
            ctl_d.im  = bus_wdata[CB_IM];
            ctl_d.slm = bus_wdata[CB_SLM];
            if (bus_wdata[CB_CI]) ctl_d.ei = 1'b0;
        end
        if (rd_out && q_empty) ctl_d.ei = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ctl_q <= '0;
        else        ctl_q <= ctl_d;
    end

    rng_lfsr #(
        .W    (32),
        .TAPS (LFSR_TAPS),
        .SEED (LFSR_SEED)
    ) u_lfsr (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (!ctl_q.slm),
        .mix_en  (wr_ent),
        .mix_val (bus_wdata),
        .state   (rnd_word)
    );

    rng_cadence #(
        .PERIOD (PERIOD)
    ) u_cad (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (ctl_q.go && !ctl_q.slm),
        .clear (!ctl_q.go),
        .tick  (tick)
    );

    rng_fifo #(
        .W     (32),
        .DEPTH (DEPTH)
    ) u_fifo (
        .clk       (clk),
        .rst_n     (rst_n),
        .push      (tick),
        .push_data (rnd_word),
        .pop       (rd_out),
        .head      (q_head),
        .level     (q_level),
        .empty     (q_empty)
    );

    always_comb begin
        bus_rdata = '0;
        if (bus_sel && !bus_we) begin
            case (bus_word)
                REG_CTRL: bus_rdata = {27'd0, ctl_q.slm, 1'b0, ctl_q.im,
                                       ctl_q.ha, ctl_q.go};
                REG_STAT: bus_rdata = {8'd0, 8'(DEPTH), 8'(q_level), 3'd0,
                                       ctl_q.slm, 1'b0, ctl_q.ei, 2'd0};
                REG_OUT:  bus_rdata = q_empty ? 32'd0 : q_head;
                default:  bus_rdata = '0;
            endcase
        end
    end

    assign irq = ctl_q.ei && !ctl_q.im;

    // R3
    push_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tick |-> (ctl_q.go && !ctl_q.slm));

    // R7
    empty_read_ei_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_out && q_empty) |=> ctl_q.ei);

    // R9
    ci_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_ctl && bus_wdata[CB_CI]) |=> !ctl_q.ei);

    // R8
    irq_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ctl_q.im |-> !irq);
endmodule

// File: tb/rand_word_gen_tb.sv
module rand_word_gen_tb;
    localparam time CLK_PERIOD = 10ns;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_sel = 1'b0;
    logic        bus_we = 1'b0;
    logic [1:0]  bus_word = 2'd0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        irq;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    rand_word_gen u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_sel   (bus_sel),
        .bus_we    (bus_we),
        .bus_word  (bus_word),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .irq       (irq)
    );

    function automatic logic [31:0] lvl_of(logic [31:0] st);
        return (st >> 8) & 32'hFF;
    endfunction

    function automatic logic [31:0] ctl_expect(logic [31:0] wr);
        return wr & 32'h17;
    endfunction

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(logic [1:0] w, logic [31:0] d);
        bus_sel = 1'b1; bus_we = 1'b1; bus_word = w; bus_wdata = d;
        @(posedge clk); #1;
        bus_sel = 1'b0; bus_we = 1'b0;
    endtask

    task automatic peek(logic [1:0] w, output logic [31:0] d);
        bus_sel = 1'b1; bus_we = 1'b0; bus_word = w;
        #1 d = bus_rdata;
        bus_sel = 1'b0;
    endtask

    task automatic pop(output logic [31:0] d);
        bus_sel = 1'b1; bus_we = 1'b0; bus_word = 2'd3;
        #1 d = bus_rdata;
        @(posedge clk); #1;
        bus_sel = 1'b0;
    endtask

    task automatic idle(int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    endtask

    initial begin
        #(CLK_PERIOD * 50000);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog actual=timeout expected=completion");
            finish_run();
        end
    end

    initial begin
        logic [31:0] v, prev;
        int r;
        void'($urandom(32'd20240607));

        idle(3);
        rst_n = 1'b1;
        idle(2);

        // R1 reset values
        peek(2'd1, v); check("R1 status", v, 32'h0010_0000);
        peek(2'd0, v); check("R1 control", v, 32'h0);
        check("R1 irq", {31'd0, irq}, 32'd0);
        // R2 entropy reads zero
        peek(2'd2, v); check("R2 entropy read", v, 32'h0);

        // R3 no pushes without enable
        idle(600);
        peek(2'd1, v); check("R3 level idle", lvl_of(v), 32'd0);

        // R4 / R11 / R2: cadence with random disturbing writes
        wr(2'd0, 32'h1);
        for (int p = 1; p <= 4; p++) begin
            for (int c = 1; c <= 255; c++) begin
                r = int'($urandom_range(0, 7));
                if (r < 2) begin
                    bus_sel = 1'b1; bus_we = 1'b1; bus_word = 2'd2; bus_wdata = $urandom();
                end else if (r == 2) begin
                    bus_sel = 1'b1; bus_we = 1'b1; bus_word = 2'd1; bus_wdata = $urandom();
                end else if (r == 3) begin
                    bus_sel = 1'b1; bus_we = 1'b1; bus_word = 2'd3; bus_wdata = $urandom();
                end
                @(posedge clk); #1;
                bus_sel = 1'b0; bus_we = 1'b0;
            end
            peek(2'd1, v); check("R4 level before tick", lvl_of(v), 32'(p - 1));
            idle(1);
            peek(2'd1, v); check("R4 R11 level on tick", lvl_of(v), 32'(p));
        end

        // R5 fill up and hold at capacity
        idle(12 * 256 + 100);
        peek(2'd1, v); check("R5 level full", lvl_of(v), 32'd16);
        check("R5 capacity field", (v >> 16) & 32'hFF, 32'd16);
        idle(600);
        peek(2'd1, v); check("R5 level stays full", lvl_of(v), 32'd16);

        // R6 / R11 drain with generation off
        wr(2'd0, 32'h0);
        prev = 32'h0;
        for (int i = 0; i < 16; i++) begin
            pop(v);
            check("R11 word nonzero", {31'd0, v != 32'h0}, 32'd1);
            if (i > 0) check("R11 words differ", {31'd0, v != prev}, 32'd1);
            prev = v;
            peek(2'd1, v); check("R6 level after pop", lvl_of(v), 32'(15 - i));
        end

        // R7 / R8 / R9 error flag
        pop(v); check("R7 empty read data", v, 32'h0);
        peek(2'd1, v); check("R7 ei set", v & 32'h4, 32'h4);
        check("R8 irq unmasked", {31'd0, irq}, 32'd1);
        wr(2'd0, 32'h4);
        check("R8 irq masked", {31'd0, irq}, 32'd0);
        peek(2'd1, v); check("R8 ei kept under mask", v & 32'h4, 32'h4);
        wr(2'd0, 32'hC);
        peek(2'd1, v); check("R9 ei cleared", v & 32'h4, 32'h0);
        peek(2'd0, v); check("R9 R2 ci reads zero", v, 32'h4);
        wr(2'd0, 32'h0);
        check("R8 irq after clear", {31'd0, irq}, 32'd0);

        // R2 reserved bits / R10 sleep indication
        wr(2'd0, 32'hFFFF_FFFF);
        peek(2'd0, v); check("R2 control readback", v, ctl_expect(32'hFFFF_FFFF));
        peek(2'd1, v); check("R10 sleep bit", v & 32'h10, 32'h10);
        wr(2'd0, 32'h0);
        peek(2'd1, v); check("R10 sleep bit clear", v & 32'h10, 32'h0);

        // R10 sleep in mid window holds the count
        wr(2'd0, 32'h1);
        idle(99);
        wr(2'd0, 32'h11);
        idle(300);
        peek(2'd1, v); check("R10 no push asleep", lvl_of(v), 32'd0);
        wr(2'd0, 32'h1);
        idle(155);
        peek(2'd1, v); check("R10 before resumed tick", lvl_of(v), 32'd0);
        idle(1);
        peek(2'd1, v); check("R10 resumed tick", lvl_of(v), 32'd1);

        // R12 disabling discards partial count
        idle(150);
        wr(2'd0, 32'h0);
        wr(2'd0, 32'h1);
        idle(255);
        peek(2'd1, v); check("R12 full wait after re-enable", lvl_of(v), 32'd1);
        idle(1);
        peek(2'd1, v); check("R12 tick after re-enable", lvl_of(v), 32'd2);

        done = 1;
        finish_run();
    end
endmodule